// File: doc/BRIEF.md
# I2C Byte-Primitive Master with Clock Stretching

This block drives a two-wire I2C bus as the master. It does not run whole transactions. It runs one primitive at a time: a start condition (which also serves as a repeated start), a stop condition, a byte write, or a byte read. A byte read ends with either an acknowledge or a not-acknowledge, chosen per command. A controller builds a transfer out of these steps, for example start, address byte, register byte, repeated start, address byte, reads, stop. The controller waits for the done pulse after each step.

Both bus lines are open-drain. The block only enables a pull-low on each line, and it never drives a line high. It reads the real line levels back through a two-stage synchronizer. Every SCL high phase begins only after the synchronized SCL is seen high. A slave that holds SCL low therefore stretches the clock for as long as it needs. Bit timing comes from a half-period count of system clocks. Each low phase is split into a hold part and a data-setup part, so SDA moves only while SCL is already low.

Top module: `i2c_prim_master`

## Requirements
- R1: During and after reset, both pull-low outputs are 0 (line released), busy and done are 0, and rx_data and rx_nack are 0. An output value of 1 means "pull this line low"; no line is ever driven high.
- R2: Command code 2'b00 (start) releases SDA, then releases SCL, then pulls SDA low while SCL is high, then pulls SCL low. It creates exactly one start condition (SDA falling while SCL is high), both from an idle bus and as a repeated start with SCL low. It leaves both lines low.
- R3: Command code 2'b01 (stop) pulls SDA low, then releases SCL, then releases SDA while SCL is high. It creates exactly one stop condition (SDA rising while SCL is high) and leaves both lines released.
- R4: A byte command (write or read) produces exactly nine SCL high pulses. Data travels most significant bit first. SDA never changes while SCL is high during a byte command, so no start or stop condition appears.
- R5: Command code 2'b10 (write) puts cmd_wdata on SDA. The block releases SDA during the ninth pulse and samples it there. rx_nack shows that sample at done: 0 means ACK (line low) and 1 means NACK.
- R6: Command code 2'b11 (read) releases SDA for eight pulses and gathers the byte into rx_data, MSB first. In the ninth pulse it pulls SDA low when cmd_ack is 1 (ACK) and leaves SDA released when cmd_ack is 0 (NACK, used for the last byte).
- R7: After releasing SCL, the block waits until the synchronized SCL reads high before it times the high phase. A slave holding SCL low stretches the clock without losing data. Every SCL high phase and every low phase lasts at least HALF_CYC clocks.
- R8: A command is accepted when cmd_valid is 1 and busy is 0. Busy is 1 from the cycle after acceptance. When the command finishes, done is 1 for exactly one cycle, and busy is already 0 in that cycle.
- R9: cmd_valid while busy is 1 has no effect. The pending command is neither queued nor run: no extra bus condition appears, and busy and done stay 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when busy is 0 |
| cmd_op | input | 2 | 00 start, 01 stop, 10 write byte, 11 read byte |
| cmd_wdata | input | 8 | Byte to send on a write |
| cmd_ack | input | 1 | On a read: 1 sends ACK, 0 sends NACK |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| rx_data | output | 8 | Byte gathered by the last read |
| rx_nack | output | 1 | Acknowledge level sampled by the last write (1 = NACK) |
| scl_i | input | 1 | Actual SCL line level |
| sda_i | input | 1 | Actual SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Some faults are visible at the ports within one byte command. A miscounted bit index gives eight or ten SCL rises instead of nine. It also gives a shifted byte at the slave, or in rx_data at the done pulse that closes the same command. A timer or stretch-wait fault shows up as a high or low phase shorter than HALF_CYC clocks, or as a corrupted read when a slave holds SCL. A phase-sequencing fault shows up as a spurious start or stop condition inside a byte, or as busy never falling. The bench checks every byte value in both directions.

// File: rtl/i2c_prim_pkg.sv
package i2c_prim_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned FRAME_W = BYTE_W + 1;

    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_STOP  = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } i2c_op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SA_REL,
        PH_SA_RISE,
        PH_SA_HIGH,
        PH_SA_FALL,
        PH_SA_LOW,
        PH_SP_LOW,
        PH_SP_RISE,
        PH_SP_HIGH,
        PH_SP_REL,
        PH_BT_LOW,
        PH_BT_SET,
        PH_BT_RISE,
        PH_BT_HIGH,
        PH_BT_END
    } phase_e;

    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
    } line_drv_t;

    // Released-level frame to shift out: a 1 bit means "release SDA".
    function automatic logic [FRAME_W-1:0] frame_for(
        input i2c_op_e          op,
        input logic [BYTE_W-1:0] data,
        input logic             ack
    );
        if (op == OP_WRITE) begin
            return {data, 1'b1};
        end
        return {{BYTE_W{1'b1}}, ~ack};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] line_in,
    output logic [LINES-1:0] line_out
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], line_in[g]};
                end
            end
            assign line_out[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/i2c_frame_shift.sv
module i2c_frame_shift #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         bit_in,
    output logic         tx_bit,
    output logic [W-1:0] word
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= load_val;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], bit_in};
        end
    end

    assign tx_bit = sh_q[W-1];
    assign word   = sh_q;

endmodule

// File: rtl/i2c_prim_master.sv
module i2c_prim_master
    import i2c_prim_pkg::*;
#(
    parameter int unsigned HALF_CYC    = 250,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_wdata,
    input  logic              cmd_ack,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_nack,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull,
    output logic              sda_pull
);

    localparam int unsigned QTR_CYC = HALF_CYC / 2;
    localparam int unsigned CNT_W   = $clog2(HALF_CYC + 1);
    localparam int unsigned BIT_W   = $clog2(FRAME_W + 1);

    localparam logic [CNT_W-1:0] LD_HALF = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] LD_QTR  = CNT_W'(QTR_CYC - 1);
    localparam logic [CNT_W-1:0] LD_SET  = CNT_W'(HALF_CYC - QTR_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    // Synchronized line levels
    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;

    i2c_line_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_in  ({scl_i, sda_i}),
        .line_out (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    // Phase timer
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;

    i2c_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // Shared transmit / receive frame register
    logic               sh_load;
    logic               sh_shift;
    logic               tx_bit;
    logic [FRAME_W-1:0] frame_word;
    logic [FRAME_W-1:0] frame_init;

    assign frame_init = frame_for(i2c_op_e'(cmd_op), cmd_wdata, cmd_ack);

    i2c_frame_shift #(
        .W (FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (frame_init),
        .shift    (sh_shift),
        .bit_in   (sda_s),
        .tx_bit   (tx_bit),
        .word     (frame_word)
    );

    // Sequencer state
    phase_e           ph_q, ph_n;
    i2c_op_e          op_q;
    logic [BIT_W-1:0] bit_q;
    logic             accept;
    logic             bit_clr;
    logic             bit_inc;
    logic             fin;
    line_drv_t        drv_q, drv_n;
    logic             done_q;
    logic [BYTE_W-1:0] rx_data_q;
    logic             rx_nack_q;

    always_comb begin
        ph_n     = ph_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        accept   = 1'b0;
        bit_clr  = 1'b0;
        bit_inc  = 1'b0;
        fin      = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (cmd_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    unique case (i2c_op_e'(cmd_op))
                        OP_START: begin
                            ph_n    = PH_SA_REL;
                            tmr_val = LD_HALF;
                        end
                        OP_STOP: begin
                            ph_n    = PH_SP_LOW;
                            tmr_val = LD_HALF;
                        end
                        default: begin
                            ph_n    = PH_BT_LOW;
                            tmr_val = LD_QTR;
                            sh_load = 1'b1;
                            bit_clr = 1'b1;
                        end
                    endcase
                end
            end
            PH_SA_REL: begin
                if (tmr_exp) ph_n = PH_SA_RISE;
            end
            PH_SA_RISE: begin
                if (scl_s) begin
                    ph_n     = PH_SA_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HALF;
                end
            end
            PH_SA_HIGH: begin
                if (tmr_exp) begin
                    ph_n     = PH_SA_FALL;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HALF;
                end
            end
            PH_SA_FALL: begin
                if (tmr_exp) begin
                    ph_n     = PH_SA_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HALF;
                end
            end
            PH_SA_LOW: begin
                if (tmr_exp) begin
                    ph_n = PH_IDLE;
                    fin  = 1'b1;
                end
            end
            PH_SP_LOW: begin
                if (tmr_exp) ph_n = PH_SP_RISE;
            end
            PH_SP_RISE: begin
                if (scl_s) begin
                    ph_n     = PH_SP_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HALF;
                end
            end
            PH_SP_HIGH: begin
                if (tmr_exp) begin
                    ph_n     = PH_SP_REL;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HALF;
                end
            end
            PH_SP_REL: begin
                if (tmr_exp) begin
                    ph_n = PH_IDLE;
                    fin  = 1'b1;
                end
            end
            PH_BT_LOW: begin
                if (tmr_exp) begin
                    ph_n     = PH_BT_SET;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SET;
                end
            end
            PH_BT_SET: begin
                if (tmr_exp) ph_n = PH_BT_RISE;
            end
            PH_BT_RISE: begin
                if (scl_s) begin
                    ph_n     = PH_BT_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HALF;
                end
            end
            PH_BT_HIGH: begin
                if (tmr_exp) begin
                    sh_shift = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_QTR;
                    if (bit_q == LAST_BIT) begin
                        ph_n = PH_BT_END;
                    end else begin
                        ph_n    = PH_BT_LOW;
                        bit_inc = 1'b1;
                    end
                end
            end
            PH_BT_END: begin
                if (tmr_exp) begin
                    ph_n = PH_IDLE;
                    fin  = 1'b1;
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    // Line drive decided from the phase being entered
    always_comb begin
        drv_n = drv_q;
        unique case (ph_n)
            PH_SA_REL:  drv_n.sda_pull = 1'b0;
            PH_SA_RISE,
            PH_SA_HIGH: drv_n = '{scl_pull: 1'b0, sda_pull: 1'b0};
            PH_SA_FALL: drv_n = '{scl_pull: 1'b0, sda_pull: 1'b1};
            PH_SA_LOW:  drv_n = '{scl_pull: 1'b1, sda_pull: 1'b1};
            PH_SP_LOW:  drv_n.sda_pull = 1'b1;
            PH_SP_RISE,
            PH_SP_HIGH: drv_n = '{scl_pull: 1'b0, sda_pull: 1'b1};
            PH_SP_REL:  drv_n = '{scl_pull: 1'b0, sda_pull: 1'b0};
            PH_BT_LOW:  drv_n.scl_pull = 1'b1;
            PH_BT_SET:  drv_n = '{scl_pull: 1'b1, sda_pull: ~tx_bit};
            PH_BT_RISE,
            PH_BT_HIGH: drv_n.scl_pull = 1'b0;
            PH_BT_END:  drv_n.scl_pull = 1'b1;
            default:    drv_n = drv_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_IDLE;
            op_q      <= OP_START;
            bit_q     <= '0;
            drv_q     <= '{scl_pull: 1'b0, sda_pull: 1'b0};
            done_q    <= 1'b0;
            rx_data_q <= '0;
            rx_nack_q <= 1'b0;
        end else begin
            ph_q   <= ph_n;
            drv_q  <= drv_n;
            done_q <= fin;
            if (accept) begin
                op_q <= i2c_op_e'(cmd_op);
            end
            if (bit_clr) begin
                bit_q <= '0;
            end else if (bit_inc) begin
                bit_q <= bit_q + 1'b1;
            end
            if (fin && op_q == OP_READ) begin
                rx_data_q <= frame_word[FRAME_W-1:1];
            end
            if (fin && op_q == OP_WRITE) begin
                rx_nack_q <= frame_word[0];
            end
        end
    end

    assign busy     = (ph_q != PH_IDLE);
    assign done     = done_q;
    assign rx_data  = rx_data_q;
    assign rx_nack  = rx_nack_q;
    assign scl_pull = drv_q.scl_pull;
    assign sda_pull = drv_q.sda_pull;

endmodule

// File: rtl/i2c_prim_master_chk.sv
module i2c_prim_master_chk
    import i2c_prim_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    cmd_valid,
    input logic    busy,
    input logic    done,
    input logic    scl_pull,
    input logic    sda_pull,
    input logic    scl_s,
    input i2c_op_e op_q
);

    // R8: completion pulse lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: busy already low when done is shown
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: an offered command while idle makes the block busy
    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy) |=> busy);

    // R9: a request while busy does not replace the running command
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> $stable(op_q));

    // R4: SDA drive moves with SCL released only in start/stop commands
    assert_sda_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!scl_pull && !$past(scl_pull) && (sda_pull != $past(sda_pull)))
            |-> (op_q == OP_START || op_q == OP_STOP));

    // R7: SCL is pulled low only after the line was seen high
    assert_stretch_seen_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pull) |-> $past(scl_s));

endmodule

bind i2c_prim_master i2c_prim_master_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .scl_s     (scl_s),
    .op_q      (op_q)
);

// File: tb/i2c_prim_master_tb_top.sv
module i2c_prim_master_tb_top;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_wdata = 8'h00;
    logic       cmd_ack = 1'b0;
    logic       busy, done, rx_nack, scl_pull, sda_pull;
    logic [7:0] rx_data;
    logic       s_scl = 1'b0;
    logic       s_sda = 1'b0;

    wire scl_line = !(scl_pull || s_scl);
    wire sda_line = !(sda_pull || s_sda);

    always #5 clk = ~clk;

    i2c_prim_master #(.HALF_CYC(HALF), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_wdata (cmd_wdata),
        .cmd_ack   (cmd_ack),
        .busy      (busy),
        .done      (done),
        .rx_data   (rx_data),
        .rx_nack   (rx_nack),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus monitor
    int  starts = 0, stops = 0, rises = 0, viol = 0;
    int  hi_run = 0, lo_run = 0;
    int  min_hi = 1000000, min_lo = 1000000;
    bit  seen_fall = 1'b0;
    bit  in_byte = 1'b0;
    logic pscl = 1'b1, psda = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (pscl && scl_line && (sda_line != psda)) begin
                if (!sda_line) starts++;
                else stops++;
                if (in_byte) viol++;
            end
            if (!pscl && scl_line) begin
                rises++;
                if (lo_run < min_lo) min_lo = lo_run;
                lo_run = 0;
            end
            if (pscl && !scl_line) begin
                if (seen_fall && hi_run < min_hi) min_hi = hi_run;
                seen_fall = 1'b1;
                hi_run = 0;
            end
            if (scl_line) hi_run++;
            else lo_run++;
            pscl = scl_line;
            psda = sda_line;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 195000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] d, input logic ak, input int junk);
        int n;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_wdata = d;
        cmd_ack   = ak;
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        if (junk > 0) begin
            cmd_op    = 2'b01;
            cmd_wdata = ~d;
            repeat (junk) @(negedge clk);
        end
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R8 done seen", done, 1);
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
    endtask

    task automatic do_write(input logic [7:0] d, input logic sack, input int junk);
        int s0, p0, r0;
        logic [7:0] got;
        s0 = starts; p0 = stops; r0 = rises;
        got = 8'h00;
        in_byte = 1'b1;
        fork
            run_cmd(2'b10, d, 1'b0, junk);
            begin
                for (int i = 0; i < 8; i++) begin
                    @(posedge scl_line);
                    #1 got[7-i] = sda_line;
                    @(negedge scl_line);
                    #1;
                    if (i == 7) s_sda = sack;
                end
                @(posedge scl_line);
                @(negedge scl_line);
                #1 s_sda = 1'b0;
            end
        join
        in_byte = 1'b0;
        chk(got == d, "R4 R5 write byte MSB first", got, d);
        chk(rx_nack == !sack, "R5 ack report", rx_nack, !sack);
        chk(rises - r0 == 9, "R4 nine pulses", rises - r0, 9);
        chk(starts == s0 && stops == p0, "R4 no condition in byte", starts - s0 + stops - p0, 0);
    endtask

    task automatic do_read(input logic [7:0] d, input logic ak, input int stretch);
        int r0;
        logic mack;
        r0 = rises;
        mack = 1'b0;
        in_byte = 1'b1;
        fork
            run_cmd(2'b11, 8'h00, ak, 0);
            begin
                s_sda = !d[7];
                if (stretch > 0) begin
                    s_scl = 1'b1;
                    repeat (stretch) @(negedge clk);
                    chk(busy == 1'b1 && rises == r0, "R7 waits while held", rises - r0, 0);
                    s_scl = 1'b0;
                end
                for (int i = 0; i < 8; i++) begin
                    @(posedge scl_line);
                    @(negedge scl_line);
                    #1;
                    if (i < 7) s_sda = !d[6-i];
                    else s_sda = 1'b0;
                end
                @(posedge scl_line);
                #1 mack = sda_line;
                @(negedge scl_line);
            end
        join
        in_byte = 1'b0;
        chk(rx_data == d, "R6 read byte", rx_data, d);
        chk(mack == !ak, "R6 ack level sent", mack, !ak);
        chk(rises - r0 == 9, "R4 nine pulses on read", rises - r0, 9);
    endtask

    initial begin
        int s0, p0;
        repeat (3) @(negedge clk);
        chk(scl_pull == 0 && sda_pull == 0, "R1 lines released in reset", {scl_pull, sda_pull}, 0);
        chk(busy == 0 && done == 0, "R1 idle in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_data == 0 && rx_nack == 0, "R1 rx regs cleared", {rx_data, rx_nack}, 0);
        chk(scl_line == 1 && sda_line == 1 && busy == 0, "R1 idle after reset", {scl_line, sda_line, busy}, 6);

        s0 = starts;
        run_cmd(2'b00, 8'h00, 1'b0, 0);
        chk(starts == s0 + 1, "R2 start from idle", starts - s0, 1);
        chk(scl_line == 0 && sda_line == 0, "R2 lines low after start", {scl_line, sda_line}, 0);

        for (int v = 0; v < 256; v++) begin
            p0 = stops;
            do_write(8'(v), (v % 3) != 0, (v % 64 == 5) ? 5 : 0);
            if (v % 64 == 5) begin
                for (int k = 0; k < 2 * HALF; k++) begin
                    @(negedge clk);
                    if (busy || done) break;
                end
                chk(!busy && !done, "R9 busy request ignored", {busy, done}, 0);
                chk(stops == p0, "R9 no stop issued", stops - p0, 0);
            end
        end

        s0 = starts;
        run_cmd(2'b00, 8'h00, 1'b0, 0);
        chk(starts == s0 + 1, "R2 repeated start", starts - s0, 1);

        for (int v = 0; v < 256; v++) begin
            do_read(8'(v) ^ 8'h3C, (v != 255) && v[1], (v % 32 == 7) ? 40 : 0);
        end

        p0 = stops;
        run_cmd(2'b01, 8'h00, 1'b0, 0);
        chk(stops == p0 + 1, "R3 one stop", stops - p0, 1);
        chk(scl_line == 1 && sda_line == 1, "R3 lines released", {scl_line, sda_line}, 3);

        chk(min_hi >= HALF, "R7 min high phase", min_hi, HALF);
        chk(min_lo >= HALF, "R7 min low phase", min_lo, HALF);
        chk(viol == 0, "R4 sda stable while scl high", viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule